// File: doc/BRIEF.md
# Masked Watchpoint and Breakpoint Comparator

This block watches the core's bus and raises a halt request when a cycle matches one of two programmed watchpoints. Each watchpoint has a value and a mask for the address, for the data and for a three-bit control field. The control field covers the transfer direction, whether the cycle is an instruction fetch, and whether the access is privileged. A mask bit of 1 makes the matching bit a don't-care. A unit matches when every unmasked bit of address, data and control equals its programmed value.

A unit can be put in breakpoint mode. It then counts a match only when the execute-qualify input shows that the instruction was actually executed, so fetches that are later flushed are ignored. Typical use is to match fetch cycles at one instruction address in ROM or RAM.

A debug register port programs and reads all watchpoint fields, a control register and a status register. This port stands in for the scan-chain path of a debug controller and is separate from the processor bus. The halt request is registered and stays asserted until software clears it. The status register shows which units have matched.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, halt_req is 0 and every register index 0 to 15 reads 0, so both units are disabled.
- R2: Unit u has its fields at index {u,3'bxxx}. Field 0 is the address value, 1 the address mask, 2 the data value, 3 the data mask, and 4 the control field, with the value in bits [2:0] and the mask in bits [10:8]. Index 6 is control: bit 0 enables unit 0, bit 1 enables unit 1, bit 4 sets breakpoint mode for unit 0, bit 5 for unit 1. Index 7 is status. Fields read back what was written, with unused bits as 0. Writes to any other index are ignored, and those indices read 0.
- R3: An enabled unit matches only when ((bus_addr ^ value) & ~mask) is 0, and a mask bit of 1 means don't care.
- R4: The same masked rule applies to bus_data and to the control field {bus_priv, bus_fetch, bus_write} (bit 2, bit 1, bit 0). A match needs address, data and control to match together.
- R5: A disabled unit never matches.
- R6: A unit in breakpoint mode matches only in a cycle where exec_ok is 1.
- R7: The match sets halt_req on the clock edge that ends the matching cycle. halt_req then stays 1 until it is cleared.
- R8: Status bit u (at index 7) records that unit u has matched, and both bits may be set in the same cycle. Status bit 4 mirrors halt_req.
- R9: Writing control with bit 8 set clears halt_req and both status match bits. If a match occurs in that same cycle, the match wins and its bits are set.
- R10: A cycle with bus_valid at 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | W | Bus address |
| bus_data | input | W | Bus data |
| bus_write | input | 1 | 1 for a write cycle |
| bus_fetch | input | 1 | 1 for an instruction fetch |
| bus_priv | input | 1 | 1 for a privileged access |
| exec_ok | input | 1 | Instruction of this cycle is executed |
| halt_req | output | 1 | Sticky halt request |

## Verification
Random 32-bit bus values almost never hit a watchpoint. The hardest case to reach is a match where the masked bits differ and the unmasked bits agree. The stimulus therefore builds many bus cycles from the programmed values, flipping only masked bits, and sometimes also one unmasked bit to get a near miss. Directed cycles cover the rarer cases: a clear and a match in the same cycle, both units matching at once, and a breakpoint fetch with exec_ok low.

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [3:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         bus_valid,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  logic         bus_write,
  input  logic         bus_fetch,
  input  logic         bus_priv,
  input  logic         exec_ok,
  output logic         halt_req
);
  localparam int NU = 2;
  localparam int CW = 3;
  localparam int MSKPOS = 8;

  logic [W-1:0]  av [NU];
  logic [W-1:0]  am [NU];
  logic [W-1:0]  dv [NU];
  logic [W-1:0]  dm [NU];
  logic [CW-1:0] cv [NU];
  logic [CW-1:0] cm [NU];
  logic [NU-1:0] en, bp, hit, st;
  logic          halt_q;

  wire [CW-1:0] bus_ctl = {bus_priv, bus_fetch, bus_write};
  wire          ctl_wr  = reg_wr && (reg_addr == 4'h6);
  wire          clr     = ctl_wr && reg_wdata[8];

  for (genvar u = 0; u < NU; u++) begin : g_cmp
    wire a_ok = ~|((bus_addr ^ av[u]) & ~am[u]);
    wire d_ok = ~|((bus_data ^ dv[u]) & ~dm[u]);
    wire c_ok = ~|((bus_ctl  ^ cv[u]) & ~cm[u]);
    assign hit[u] = bus_valid && en[u] && (!bp[u] || exec_ok) && a_ok && d_ok && c_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        av[u] <= '0; am[u] <= '0; dv[u] <= '0; dm[u] <= '0;
        cv[u] <= '0; cm[u] <= '0;
      end
    end else if (reg_wr) begin
      for (int u = 0; u < NU; u++) begin
        if (reg_addr[3] == 1'(u)) begin
          case (reg_addr[2:0])
            3'd0: av[u] <= reg_wdata;
            3'd1: am[u] <= reg_wdata;
            3'd2: dv[u] <= reg_wdata;
            3'd3: dm[u] <= reg_wdata;
            3'd4: begin
              cv[u] <= reg_wdata[CW-1:0];
              cm[u] <= reg_wdata[MSKPOS +: CW];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      bp     <= '0;
      st     <= '0;
      halt_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en <= reg_wdata[NU-1:0];
        bp <= reg_wdata[4 +: NU];
      end
      st     <= (clr ? '0 : st) | hit;
      halt_q <= (clr ? 1'b0 : halt_q) | (|hit);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 4'h6) begin
      reg_rdata[NU-1:0] = en;
      reg_rdata[4 +: NU] = bp;
    end else if (reg_addr == 4'h7) begin
      reg_rdata[NU-1:0] = st;
      reg_rdata[4] = halt_q;
    end else begin
      case (reg_addr[2:0])
        3'd0: reg_rdata = av[reg_addr[3]];
        3'd1: reg_rdata = am[reg_addr[3]];
        3'd2: reg_rdata = dv[reg_addr[3]];
        3'd3: reg_rdata = dm[reg_addr[3]];
        3'd4: begin
          reg_rdata[CW-1:0] = cv[reg_addr[3]];
          reg_rdata[MSKPOS +: CW] = cm[reg_addr[3]];
        end
        default: ;
      endcase
    end
  end

  assign halt_req = halt_q;

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !clr) |=> halt_q);
  assert_halt_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (st != '0));
  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !en[1]) |=> (st == '0 || $stable(st) || $fell(st[0]) || $fell(st[1])));
  assert_bp_needs_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp[0] && !exec_ok && !st[0]) |=> !st[0]);
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && clr) |=> (st == '0 && !halt_q));
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit == '0) |=> !halt_q);
endmodule

// File: tb/dbg_watch_unit_bench.sv
module dbg_watch_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic        bus_write = 0, bus_fetch = 0, bus_priv = 0, exec_ok = 0;
  logic        halt_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_av [2], m_am [2], m_dv [2], m_dm [2];
  logic [2:0]  m_cv [2], m_cm [2];
  logic [1:0]  m_en = 0, m_bp = 0, m_st = 0;
  logic        m_halt = 0;

  dbg_watch_unit #(.W(32)) u_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
    .bus_fetch(bus_fetch), .bus_priv(bus_priv), .exec_ok(exec_ok),
    .halt_req(halt_req));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(int u, bit v, logic [31:0] a, logic [31:0] d,
                                 logic [2:0] c, bit x);
    if (!v || !m_en[u]) return 0;
    if (m_bp[u] && !x) return 0;
    if (((a ^ m_av[u]) & ~m_am[u]) != 0) return 0;
    if (((d ^ m_dv[u]) & ~m_dm[u]) != 0) return 0;
    if (((c ^ m_cv[u]) & ~m_cm[u]) != 0) return 0;
    return 1;
  endfunction

  task automatic cyc(string tag, bit wr, logic [3:0] a, logic [31:0] wd, bit v,
                     logic [31:0] ba, logic [31:0] bd, logic [2:0] c, bit x);
    logic [1:0] h;
    bit clr;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    bus_valid = v; bus_addr = ba; bus_data = bd;
    {bus_priv, bus_fetch, bus_write} = c; exec_ok = x;
    h = {exp_hit(1, v, ba, bd, c, x), exp_hit(0, v, ba, bd, c, x)};
    clr = wr && a == 4'h6 && wd[8];
    m_st = (clr ? 2'b00 : m_st) | h;
    m_halt = (clr ? 1'b0 : m_halt) | (|h);
    if (wr) begin
      if (a == 4'h6) begin m_en = wd[1:0]; m_bp = wd[5:4]; end
      else if (a != 4'h7) begin
        case (a[2:0])
          3'd0: m_av[a[3]] = wd;
          3'd1: m_am[a[3]] = wd;
          3'd2: m_dv[a[3]] = wd;
          3'd3: m_dm[a[3]] = wd;
          3'd4: begin m_cv[a[3]] = wd[2:0]; m_cm[a[3]] = wd[10:8]; end
          default: ;
        endcase
      end
    end
    @(posedge clk); @(negedge clk);
    reg_wr = 0; reg_addr = 4'h7; bus_valid = 0;
    #1;
    chk({tag, " R7 halt"}, 32'(halt_req), 32'(m_halt));
    chk({tag, " R8 status"}, reg_rdata, {27'd0, m_halt, 2'b00, m_st});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc("write", 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] e);
    reg_wr = 0; reg_addr = a; #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic bus(string tag, logic [31:0] ba, logic [31:0] bd, logic [2:0] c, bit x);
    cyc(tag, 0, 0, 0, 1, ba, bd, c, x);
  endtask

  task automatic clear();
    cyc("clear", 1, 4'h6, {23'd0, 1'b1, 2'b00, m_bp, 2'b00, m_en}, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      m_av[u] = 0; m_am[u] = 0; m_dv[u] = 0; m_dm[u] = 0; m_cv[u] = 0; m_cm[u] = 0;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 halt after reset", 32'(halt_req), 0);
    for (int i = 0; i < 16; i++) rd($sformatf("R1 reg %0d after reset", i), 4'(i), 0);

    for (int i = 0; i < 16; i++) begin
      logic [31:0] d = $urandom;
      logic [31:0] e;
      if (i == 6 || i == 7) continue;
      wr(4'(i), d);
      case (i & 7)
        0, 1, 2, 3: e = d;
        4: e = d & 32'h0000_0707;
        default: e = 0;
      endcase
      rd($sformatf("R2 readback %0d", i), 4'(i), e);
    end
    wr(4'h6, 32'h0000_0033);
    rd("R2 control readback", 4'h6, 32'h0000_0033);

    wr(4'h0, 32'h0000_1000); wr(4'h1, 32'h0000_000F);
    wr(4'h2, 32'h0);         wr(4'h3, 32'hFFFF_FFFF);
    wr(4'h4, 32'h0000_0002); wr(4'h6, 32'h0000_0001);
    wr(4'h8, 32'h0); wr(4'h9, 32'h0); wr(4'hA, 32'h0); wr(4'hB, 32'h0); wr(4'hC, 32'h0);
    bus("R3 unmasked bit differs", 32'h0000_1010, 32'h1234, 3'b010, 0);
    bus("R3 masked bits differ", 32'h0000_100A, 32'h1234, 3'b010, 0);
    clear();
    bus("R4 control mismatch", 32'h0000_1000, 32'h0, 3'b000, 0);
    wr(4'h4, 32'h0000_0502);
    bus("R4 control masked match", 32'h0000_1000, 32'h0, 3'b111, 0);
    clear();
    cyc("R10 idle bus", 0, 0, 0, 0, 32'h0000_1000, 0, 3'b010, 1);
    wr(4'h6, 32'h0000_0011);
    bus("R6 bp flushed fetch", 32'h0000_1000, 32'h0, 3'b010, 0);
    bus("R6 bp executed fetch", 32'h0000_1000, 32'h0, 3'b010, 1);
    cyc("R9 clear with match", 1, 4'h6, 32'h0000_0111, 1, 32'h0000_1000, 0, 3'b010, 1);
    clear();
    rd("R9 status after clear", 4'h7, 0);
    wr(4'h6, 32'h0000_0000);
    bus("R5 disabled unit", 32'h0000_1000, 32'h0, 3'b010, 1);
    wr(4'h8, 32'h0000_1000); wr(4'h9, 32'h0); wr(4'hA, 32'h0); wr(4'hB, 32'h0);
    wr(4'hC, 32'h0000_0002); wr(4'h6, 32'h0000_0003);
    bus("R8 both units", 32'h0000_1000, 32'h0, 3'b010, 0);
    clear();

    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) begin
        logic [3:0] a = 4'($urandom_range(0, 15));
        logic [31:0] d = $urandom;
        if (a[2:0] == 3'd1 || a[2:0] == 3'd3) d = d & $urandom & $urandom;
        if (a == 4'h7) a = 4'h6;
        if (a == 4'h6) d[8] = 0;
        cyc("R2 random write", 1, a, d, 0, 0, 0, 0, 0);
      end else if (r < 8) begin
        clear();
      end else begin
        int u = $urandom_range(0, 1);
        logic [31:0] ba = $urandom, bd = $urandom;
        logic [2:0] c = 3'($urandom);
        if (r < 80) begin
          ba = m_av[u] ^ ($urandom & m_am[u]);
          bd = m_dv[u] ^ ($urandom & m_dm[u]);
          c  = m_cv[u] ^ (3'($urandom) & m_cm[u]);
          if (r < 30) ba = ba ^ (32'd1 << $urandom_range(0, 31));
        end
        cyc("R3 R4 random bus", 0, 0, 0, $urandom_range(0, 7) != 0, ba, bd, c,
            1'($urandom));
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule